// File: doc/BRIEF.md
# SPI Event Flag, Interrupt and DMA Request Unit

This unit is the event-signalling part of an SPI peripheral. The double-buffered data path reports three kinds of single-cycle strobes: a transmit word was loaded into the shift register, a received word was loaded into the receive data register, and error conditions. The unit turns these strobes into sticky status flags. It drives level interrupt lines from the flags and their enables. It also issues one-cycle DMA request pulses for every transfer.

Software reaches the unit over a small register bus with two words. The first word is a 32-bit enable register. The second word is a flag register that software clears by writing 1 to a bit. The transmit flag is also cleared by a transmit data write, and the receive flag by a receive data read. The unit also decides whether the slave wait pin is driven high or left floating when it is not pulled low.

Top module: `spi_evt_ctrl`

## Requirements
- R1: After reset, every enable bit and every flag is 0. Both registers read as zero. No interrupt or DMA output is active.
- R2: A write to address 0 stores only bits 24 (wait-pin float enable), 16 (DMA enable), 9 (transmit interrupt enable), 8 (receive interrupt enable), 6 (overrun interrupt enable) and 4..0 (error enables). All other bits read as 0. The register keeps its value when it is not written. Addresses 2 and 3 read as 0.
- R3: The transmit flag is bit 0 at address 1. It is set on the clock after `tx_load_i`. It is cleared by `data_wr_i` or by writing 1 to bit 0 at address 1. When a set and a clear arrive in the same cycle, the set wins.
- R4: The receive flag is bit 1 at address 1. It is set on the clock after `rx_load_i`. It is cleared by `data_rd_i` or by writing 1 to bit 1 at address 1. When a set and a clear arrive in the same cycle, the set wins.
- R5: The overrun flag is bit 2 at address 1. It is set when `rx_load_i` arrives while the receive flag is already set. It is cleared only by writing 1 to bit 2 at address 1.
- R6: `tx_irq_o` is high exactly while the transmit flag and the transmit interrupt enable are both 1.
- R7: `rx_irq_o` is the OR of (receive flag AND receive enable) and (overrun flag AND overrun enable).
- R8: Error flag i is bit 8+i at address 1. It is set by `err_evt_i[i]` and cleared by writing 1 to that bit. `err_irq_o` is high while any error flag and its matching enable (bit i at address 0) are both 1.
- R9: When the DMA enable and `global_en_i` are both 1, each `tx_load_i` or `rx_load_i` gives a one-cycle high on `tx_dma_o` or `rx_dma_o` in the next cycle. Back-to-back loads give one high cycle each.
- R10: While the DMA enable or `global_en_i` is 0 at the time of a load, no DMA request follows that load.
- R11: `wait_o` is 0 while `wait_req_i` is 1 and is 1 otherwise. `wait_oe_o` is 1 while `wait_req_i` is 1. When `wait_req_i` is 0, `wait_oe_o` is the inverse of the float enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| global_en_i | input | 1 | Peripheral global enable |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for `req_i` |
| addr_i | input | 2 | Word address: 0 enables, 1 flags |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tx_load_i | input | 1 | Transmit word loaded into the shift register |
| rx_load_i | input | 1 | Received word loaded into the receive data register |
| data_wr_i | input | 1 | Transmit data write, clears the transmit flag |
| data_rd_i | input | 1 | Receive data read, clears the receive flag |
| err_evt_i | input | 5 | Error event strobes |
| wait_req_i | input | 1 | Slave requests the wait pin pulled low |
| tx_irq_o | output | 1 | Transmit interrupt level |
| rx_irq_o | output | 1 | Shared receive/overrun interrupt level |
| err_irq_o | output | 1 | Error interrupt level |
| tx_dma_o | output | 1 | Transmit DMA request pulse |
| rx_dma_o | output | 1 | Receive DMA request pulse |
| wait_o | output | 1 | Wait pin value |
| wait_oe_o | output | 1 | Wait pin output enable |

## Verification
Two kinds of event can land on one flag in the same cycle. A load can collide with a clearing data access or a write-1-to-clear. A second receive load can also arrive while the receive flag is still set, which must raise overrun. Directed cases drive each of these pairs on a single edge. Random traffic then overlaps loads, data accesses and register writes at high rates. A cycle-accurate bench model judges every flag readback and every interrupt and DMA output after each edge.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  localparam int N_ERR  = 5;

  // enable register bit positions
  localparam int HIZ_BIT  = 24;
  localparam int DMA_BIT  = 16;
  localparam int TXIE_BIT = 9;
  localparam int RXIE_BIT = 8;
  localparam int OVIE_BIT = 6;

  localparam logic [REG_W-1:0] EN_MASK =
      (REG_W'(1) << HIZ_BIT) | (REG_W'(1) << DMA_BIT) | (REG_W'(1) << TXIE_BIT) |
      (REG_W'(1) << RXIE_BIT) | (REG_W'(1) << OVIE_BIT) | ((REG_W'(1) << N_ERR) - REG_W'(1));

  // flag register read positions
  localparam int RD_TX  = 0;
  localparam int RD_RX  = 1;
  localparam int RD_OVR = 2;
  localparam int RD_ERR = 8;

  // internal flag vector indices
  localparam int FL_TX  = 0;
  localparam int FL_RX  = 1;
  localparam int FL_OVR = 2;
  localparam int FL_ERR = 3;
  localparam int N_FL   = FL_ERR + N_ERR;

  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(1);
endpackage

// File: rtl/spi_evt_regs.sv
module spi_evt_regs
  import spi_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & EN_MASK;
  end

  assign en_o = en_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_set_i,
  input  logic             rx_set_i,
  input  logic [N_ERR-1:0] err_set_i,
  input  logic             tx_clr_i,
  input  logic             rx_clr_i,
  input  logic [N_FL-1:0]  w1c_i,
  output logic [N_FL-1:0]  flags_o
);
  logic [N_FL-1:0] flag_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[FL_TX]  = tx_set_i;
    set_v[FL_RX]  = rx_set_i;
    set_v[FL_OVR] = rx_set_i & flag_q[FL_RX];  // new word over an unread one
    set_v[FL_ERR +: N_ERR] = err_set_i;
    clr_v = w1c_i;
    clr_v[FL_TX] = w1c_i[FL_TX] | tx_clr_i;
    clr_v[FL_RX] = w1c_i[FL_RX] | rx_clr_i;
  end

  for (genvar g = 0; g < N_FL; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= set_v[g] | (flag_q[g] & ~clr_v[g]);  // set wins
    end
  end

  assign flags_o = flag_q;

  a_r3_tx_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> flags_o[FL_TX]);
  a_r4_rx_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> flags_o[FL_RX]);
  a_r5_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_set_i && flags_o[FL_RX]) |=> flags_o[FL_OVR]);
  a_r5_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FL_OVR] && !w1c_i[FL_OVR]) |=> flags_o[FL_OVR]);
  a_r8_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((flags_o[FL_ERR +: N_ERR] & $past(err_set_i)) == $past(err_set_i)));
endmodule

// File: rtl/spi_evt_dma.sv
module spi_evt_dma #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [N_CH-1:0] evt_i,
  output logic [N_CH-1:0] req_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic req_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= en_i & evt_i[g];
    end
    assign req_o[g] = req_q;

    a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && evt_i[g]) |=> req_o[g]);
    a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !req_o[g]);
  end
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              global_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tx_load_i,
  input  logic              rx_load_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [N_ERR-1:0]  err_evt_i,
  input  logic              wait_req_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              err_irq_o,
  output logic              tx_dma_o,
  output logic              rx_dma_o,
  output logic              wait_o,
  output logic              wait_oe_o
);
  logic             wr_en, wr_fl;
  logic [REG_W-1:0] en;
  logic [N_FL-1:0]  flags, w1c;
  logic [1:0]       dma_req;

  assign wr_en = req_i & we_i & (addr_i == ADDR_EN);
  assign wr_fl = req_i & we_i & (addr_i == ADDR_FLAG);

  always_comb begin
    w1c = '0;
    w1c[FL_TX]  = wr_fl & wdata_i[RD_TX];
    w1c[FL_RX]  = wr_fl & wdata_i[RD_RX];
    w1c[FL_OVR] = wr_fl & wdata_i[RD_OVR];
    w1c[FL_ERR +: N_ERR] = {N_ERR{wr_fl}} & wdata_i[RD_ERR +: N_ERR];
  end

  spi_evt_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en),
    .wdata_i (wdata_i),
    .en_o    (en)
  );

  spi_evt_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_set_i  (tx_load_i),
    .rx_set_i  (rx_load_i),
    .err_set_i (err_evt_i),
    .tx_clr_i  (data_wr_i),
    .rx_clr_i  (data_rd_i),
    .w1c_i     (w1c),
    .flags_o   (flags)
  );

  spi_evt_dma #(.N_CH(2)) u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en[DMA_BIT] & global_en_i),
    .evt_i  ({rx_load_i, tx_load_i}),
    .req_o  (dma_req)
  );

  assign tx_dma_o = dma_req[0];
  assign rx_dma_o = dma_req[1];

  assign tx_irq_o  = flags[FL_TX] & en[TXIE_BIT];
  assign rx_irq_o  = (flags[FL_RX] & en[RXIE_BIT]) | (flags[FL_OVR] & en[OVIE_BIT]);
  assign err_irq_o = |(flags[FL_ERR +: N_ERR] & en[N_ERR-1:0]);

  // pin pulled low on request; released high or floated by the float enable
  assign wait_o    = ~wait_req_i;
  assign wait_oe_o = wait_req_i | ~en[HIZ_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_EN:   rdata_o = en;
      ADDR_FLAG: begin
        rdata_o[RD_TX]  = flags[FL_TX];
        rdata_o[RD_RX]  = flags[FL_RX];
        rdata_o[RD_OVR] = flags[FL_OVR];
        rdata_o[RD_ERR +: N_ERR] = flags[FL_ERR +: N_ERR];
      end
      default:   rdata_o = '0;
    endcase
  end

  a_r6_tx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (flags[FL_TX] && en[TXIE_BIT]));
  a_r7_ovr_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[FL_OVR] && en[OVIE_BIT]) |-> rx_irq_o);
  a_r11_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en[HIZ_BIT] && !wait_req_i) |-> !wait_oe_o);
  a_r11_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_i |-> (wait_oe_o && !wait_o));
endmodule

// File: tb/spi_evt_ctrl_bench.sv
module spi_evt_ctrl_bench;
  localparam logic [31:0] MASK = 32'h0101_035F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        global_en, req, we, tx_load, rx_load, data_wr, data_rd, wait_req;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  err_evt;
  logic        tx_irq, rx_irq, err_irq, tx_dma, rx_dma, wait_pin, wait_oe;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_evt_ctrl u_spi_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .global_en_i(global_en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tx_load_i(tx_load),
    .rx_load_i(rx_load), .data_wr_i(data_wr), .data_rd_i(data_rd), .err_evt_i(err_evt),
    .wait_req_i(wait_req), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq),
    .tx_dma_o(tx_dma), .rx_dma_o(rx_dma), .wait_o(wait_pin), .wait_oe_o(wait_oe)
  );

  // reference model
  logic [31:0] m_en;
  logic        m_tx, m_rx, m_ovr, m_txd, m_rxd;
  logic [4:0]  m_err;
  logic        w_en, w_fl;
  assign w_en = req && we && addr == 2'd0;
  assign w_fl = req && we && addr == 2'd1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_tx <= 0; m_rx <= 0; m_ovr <= 0; m_err <= '0; m_txd <= 0; m_rxd <= 0;
    end else begin
      if (w_en) m_en <= wdata & MASK;
      m_tx  <= tx_load | (m_tx & ~(data_wr | (w_fl & wdata[0])));
      m_rx  <= rx_load | (m_rx & ~(data_rd | (w_fl & wdata[1])));
      m_ovr <= (rx_load & m_rx) | (m_ovr & ~(w_fl & wdata[2]));
      m_err <= err_evt | (m_err & ~(w_fl ? wdata[12:8] : 5'd0));
      m_txd <= tx_load & m_en[16] & global_en;
      m_rxd <= rx_load & m_en[16] & global_en;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (addr == 2'd0)
      chk(rdata == m_en, "R2 enable readback", rdata, m_en);
    else if (addr == 2'd1) begin
      chk(rdata[0] == m_tx,  "R3 tx flag", 32'(rdata[0]), 32'(m_tx));
      chk(rdata[1] == m_rx,  "R4 rx flag", 32'(rdata[1]), 32'(m_rx));
      chk(rdata[2] == m_ovr, "R5 overrun flag", 32'(rdata[2]), 32'(m_ovr));
      chk(rdata[12:8] == m_err, "R8 error flags", 32'(rdata[12:8]), 32'(m_err));
      chk((rdata & ~32'h1F07) == 0, "R2 flag reserved bits", rdata, rdata & 32'h1F07);
    end else
      chk(rdata == 0, "R2 unused address", rdata, 0);
    chk(tx_irq == (m_tx & m_en[9]), "R6 tx irq", 32'(tx_irq), 32'(m_tx & m_en[9]));
    chk(rx_irq == ((m_rx & m_en[8]) | (m_ovr & m_en[6])), "R7 rx irq", 32'(rx_irq),
        32'((m_rx & m_en[8]) | (m_ovr & m_en[6])));
    chk(err_irq == |(m_err & m_en[4:0]), "R8 err irq", 32'(err_irq), 32'(|(m_err & m_en[4:0])));
    chk(tx_dma == m_txd, "R9 R10 tx dma", 32'(tx_dma), 32'(m_txd));
    chk(rx_dma == m_rxd, "R9 R10 rx dma", 32'(rx_dma), 32'(m_rxd));
    chk(wait_pin == ~wait_req, "R11 wait value", 32'(wait_pin), 32'(~wait_req));
    chk(wait_oe == (wait_req | ~m_en[24]), "R11 wait oe", 32'(wait_oe), 32'(wait_req | ~m_en[24]));
  endtask

  task automatic idle();
    req = 0; we = 0; addr = 2'd1; wdata = '0; tx_load = 0; rx_load = 0;
    data_wr = 0; data_rd = 0; err_evt = '0; wait_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    step();
  endtask

  initial begin
    global_en = 1'b1;
    idle();
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdata == 0 && !tx_irq && !rx_irq && !err_irq && !tx_dma && !rx_dma,
        "R1 reset flags/outputs", rdata, 0);
    addr = 2'd0; #1;
    chk(rdata == 0, "R1 reset enables", rdata, 0);
    rst_n = 1'b1;
    step();

    // R2: all ones, only defined bits stick
    wr(2'd0, 32'hFFFF_FFFF);
    addr = 2'd0; #1;
    chk(rdata == MASK, "R2 mask", rdata, MASK);
    step();

    // R3: load and data write in same cycle, set wins
    tx_load = 1; data_wr = 1; step();
    chk(tx_irq == 1'b1, "R3 set wins over data write", 32'(tx_irq), 1);
    chk(tx_dma == 1'b1, "R9 tx pulse", 32'(tx_dma), 1);
    step();
    chk(tx_dma == 1'b0, "R9 single pulse", 32'(tx_dma), 0);
    data_wr = 1; step();
    chk(tx_irq == 1'b0, "R3 cleared by data write", 32'(tx_irq), 0);

    // R4/R5: receive, then second load before read -> overrun
    rx_load = 1; step();
    rx_load = 1; data_rd = 1; step();
    chk(m_ovr == 1'b1 && rx_irq, "R5 overrun on unread word", 32'(rx_irq), 1);
    data_rd = 1; step();
    chk(rx_irq == 1'b1, "R7 overrun keeps shared line", 32'(rx_irq), 1);
    wr(2'd1, 32'h4);
    chk(rx_irq == 1'b0, "R5 w1c clears overrun", 32'(rx_irq), 0);

    // R10: global enable low suppresses DMA
    global_en = 0; tx_load = 1; rx_load = 1; step();
    chk(!tx_dma && !rx_dma, "R10 gated by global enable", 32'({tx_dma, rx_dma}), 0);
    global_en = 1;

    // R8: error flags
    err_evt = 5'b00100; step();
    chk(err_irq == 1'b1, "R8 error irq", 32'(err_irq), 1);
    wr(2'd1, 32'h0000_0400);
    chk(err_irq == 1'b0, "R8 error w1c", 32'(err_irq), 0);

    // R11: float enable
    wait_req = 1; #1;
    chk(wait_oe && !wait_pin, "R11 drive low", 32'({wait_oe, wait_pin}), 32'b10);
    step();
    #1;
    chk(!wait_oe, "R11 float when idle", 32'(wait_oe), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      global_en = ($urandom % 8) != 0;
      req = ($urandom % 5) == 0;
      we  = $urandom % 2;
      addr = 2'($urandom % 4);
      wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
      tx_load = ($urandom % 3) == 0;
      rx_load = ($urandom % 3) == 0;
      data_wr = ($urandom % 3) == 0;
      data_rd = ($urandom % 3) == 0;
      err_evt = 5'($urandom & $urandom & $urandom);
      wait_req = $urandom % 2;
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule